// File: doc/BRIEF.md
# Overflow-Interrupt Dual-Channel System Timer

This block is a memory-mapped peripheral with two identical 32-bit up-counters. Each channel counts from a start value that software loads into it. When the count passes all ones it sets a pending flag, and that flag drives a level interrupt. To ask for an event N counts ahead, software loads all-ones minus N into the start-value register, pulses the start bit, and later clears the flag by writing the status register. A second channel can run free with its interrupt masked. Its live count then serves as a monotonic time base that can be read at any time.

Register access is a single-cycle port. A write is captured on the rising clock edge while `wr_en` is high. A read is combinational: `rdata` reflects `addr` in the same cycle while `rd_en` is high, and is zero otherwise. Each channel has its own interrupt line. A programmable prescaler sets how many input clocks make up one count.

Top module: `ovt_timer_top`

## Requirements
- R1: After a synchronous active-low reset, every register of both channels reads zero, no channel counts, and both interrupt lines are low.
- R2: Channel k occupies byte offsets 0x40*k to 0x40*k+0x3F. Within a channel the registers are: status at 0x00, count at 0x04, control at 0x10, config at 0x20, divider at 0x24 and start value at 0x28. Config, divider and start value read back what was written, with config holding bit 0 = enable and bit 1 = interrupt enable.
- R3: A control write with bit 1 set and bit 0 clear loads the count from the start-value register and marks the channel running. Control bit 1 then reads 1. While the channel is running and enabled, the count rises by one per tick and is readable live at offset 0x04.
- R4: With divider 0 and start value all-ones minus N, the flag is set on the (N+1)th clock edge after the start write is captured. On that edge the count reloads the start value and counting continues.
- R5: A divider value D makes the count advance once every D+1 clocks. The first advance comes D+1 clocks after the start write.
- R6: Status bit 0 reads the pending flag. The flag stays set until software writes 1 to status bit 0. Writing 0 there has no effect.
- R7: If a status clear and an overflow land on the same clock edge, the flag stays set.
- R8: A channel's interrupt line is high exactly when its flag, its config enable and its config interrupt enable are all set.
- R9: A control write with bit 0 set stops the channel and zeroes its count, even when bit 1 is set in the same write. Control bit 1 then reads 0. The pending flag is left unchanged.
- R10: While config enable is 0, the count holds its value.
- R11: The two channels are independent. Activity on one changes neither the count, the flag nor the interrupt line of the other.
- R12: Reads of unmapped offsets return zero. This covers offsets inside a channel window that hold no register, and addresses at or above 0x80. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, captured on the rising edge |
| rd_en | input | 1 | Register read strobe, combinational data return |
| addr | input | 10 | Byte address inside the 0x400 window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not reading or unmapped |
| irq | output | 2 | Level interrupt, one bit per channel |

## Verification
The bench measures the overflow edge exactly, for the smallest delta and for a larger one. An off-by-one in the wrap compare or in the reload shows up as an interrupt one edge early or late, or as a count other than the start value after the wrap. It lands a status clear on the same edge as an overflow; a design that lets the clear win would read the flag as 0. It writes control with both bits set, where a design that gives start the priority would keep counting. It also runs the prescaler with a non-zero divider to catch a design that advances every clock. Finally, it writes to a hole inside the window and to address 0x80, where a decoder that drops the upper channel-index bits would alias onto channel 0 and corrupt its registers.

// File: rtl/ovt_pkg.sv
// Package: shared constants and types for the overflow timer.
// Assumes each channel window is 64 bytes and registers are word aligned.
package ovt_pkg;
    localparam int CH_OFS_W  = 6;
    localparam int CH_STRIDE = 64;

    localparam logic [CH_OFS_W-1:0] OFS_STAT = 6'h00;
    localparam logic [CH_OFS_W-1:0] OFS_VAL  = 6'h04;
    localparam logic [CH_OFS_W-1:0] OFS_CTRL = 6'h10;
    localparam logic [CH_OFS_W-1:0] OFS_CFG  = 6'h20;
    localparam logic [CH_OFS_W-1:0] OFS_DIV  = 6'h24;
    localparam logic [CH_OFS_W-1:0] OFS_INIT = 6'h28;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STAT,
        REG_VAL,
        REG_CTRL,
        REG_CFG,
        REG_DIV,
        REG_INIT
    } reg_sel_e;
endpackage

// File: rtl/ovt_decode.sv
// Address decoder: splits the byte address into a one-hot channel hit
// and a register selector. Assumes the window holds 64-byte channels;
// unmapped offsets and channels beyond NUM_CH give no hit.
module ovt_decode #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CH-1:0]  ch_hit,
    output ovt_pkg::reg_sel_e  reg_sel
);
    import ovt_pkg::*;

    localparam int CHW = ADDR_W - CH_OFS_W;

    logic [CHW-1:0]      ch_idx;
    logic [CH_OFS_W-1:0] offset;
    reg_sel_e            raw_sel;

    assign ch_idx = addr[ADDR_W-1:CH_OFS_W];
    assign offset = addr[CH_OFS_W-1:0];

    // Map the in-window offset to a register selector.
    always_comb begin
        case (offset)
            OFS_STAT: raw_sel = REG_STAT;
            OFS_VAL:  raw_sel = REG_VAL;
            OFS_CTRL: raw_sel = REG_CTRL;
            OFS_CFG:  raw_sel = REG_CFG;
            OFS_DIV:  raw_sel = REG_DIV;
            OFS_INIT: raw_sel = REG_INIT;
            default:  raw_sel = REG_NONE;
        endcase
    end

    // One comparator per channel, compared over the full index width.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ch_hit[i] = (ch_idx == CHW'(i)) && (raw_sel != REG_NONE);
    end

    // Report no register when the channel index is out of range.
    assign reg_sel = (|ch_hit) ? raw_sel : REG_NONE;
endmodule

// File: rtl/ovt_prescaler.sv
// Prescaler: emits one tick every DIV+1 clocks while run is high.
// Assumes clear restarts the phase; the count holds while run is low.
module ovt_prescaler #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    // A >= compare keeps the tick alive if div shrinks mid-period.
    assign tick = run && (phase >= div);

    // Advance the phase counter and wrap it on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (run) begin
            phase <= tick ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/ovt_channel.sv
// One timer channel: config, divider and start-value registers, the
// up-counter with overflow reload, the pending flag and its interrupt.
// Assumes wr_en is already qualified by the channel hit.
module ovt_channel #(
    parameter int CNT_W  = 32,
    parameter int DIV_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  ovt_pkg::reg_sel_e acc_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic              irq,
    output logic              flag,
    output logic              cfg_en,
    output logic              running,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  init_val
);
    import ovt_pkg::*;

    logic             cfg_ie;
    logic [DIV_W-1:0] div_val;
    logic             wr_stat, wr_ctrl, wr_cfg, wr_div, wr_init;
    logic             do_stop, do_go, tick, wrap;

    assign wr_stat = wr_en && (acc_sel == REG_STAT);
    assign wr_ctrl = wr_en && (acc_sel == REG_CTRL);
    assign wr_cfg  = wr_en && (acc_sel == REG_CFG);
    assign wr_div  = wr_en && (acc_sel == REG_DIV);
    assign wr_init = wr_en && (acc_sel == REG_INIT);

    // Stop has priority over start within one control write.
    assign do_stop = wr_ctrl && wdata[0];
    assign do_go   = wr_ctrl && wdata[1] && !wdata[0];

    ovt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (do_stop || do_go),
        .run   (running && cfg_en),
        .div   (div_val),
        .tick  (tick)
    );

    assign wrap = tick && (count == {CNT_W{1'b1}});

    // Config, divider and start-value register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_ie   <= 1'b0;
            div_val  <= '0;
            init_val <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_en <= wdata[0];
                cfg_ie <= wdata[1];
            end
            if (wr_div)  div_val  <= wdata[DIV_W-1:0];
            if (wr_init) init_val <= wdata[CNT_W-1:0];
        end
    end

    // Counter: stop, start, count up, and reload from the start value on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
        end else if (do_stop) begin
            count   <= '0;
            running <= 1'b0;
        end else if (do_go) begin
            count   <= init_val;
            running <= 1'b1;
        end else if (tick) begin
            count   <= wrap ? init_val : count + 1'b1;
        end
    end

    // Pending flag: set on wrap, cleared by a write of 1; a wrap wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (wr_stat && wdata[0]) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && cfg_en && cfg_ie;

    // Read data for the selected register of this channel.
    always_comb begin
        case (acc_sel)
            REG_STAT: rd_word = DATA_W'(flag);
            REG_VAL:  rd_word = DATA_W'(count);
            REG_CTRL: rd_word = DATA_W'({running, 1'b0});
            REG_CFG:  rd_word = DATA_W'({cfg_ie, cfg_en});
            REG_DIV:  rd_word = DATA_W'(div_val);
            REG_INIT: rd_word = DATA_W'(init_val);
            default:  rd_word = '0;
        endcase
    end
endmodule

// File: rtl/ovt_timer_top.sv
// Top level: decodes the register port, instantiates the channels and
// merges their read data. Assumes a single-cycle access per request.
module ovt_timer_top #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int DIV_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);
    import ovt_pkg::*;

    logic [NUM_CH-1:0]            ch_hit;
    reg_sel_e                     reg_sel;
    logic [DATA_W-1:0]            rd_word [NUM_CH];
    logic [NUM_CH-1:0]            ch_flag;
    logic [NUM_CH-1:0]            ch_en;
    logic [NUM_CH-1:0]            ch_run;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_count;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_init;

    ovt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .ch_hit  (ch_hit),
        .reg_sel (reg_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ovt_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && ch_hit[i]),
            .acc_sel  (reg_sel),
            .wdata    (wdata),
            .rd_word  (rd_word[i]),
            .irq      (irq[i]),
            .flag     (ch_flag[i]),
            .cfg_en   (ch_en[i]),
            .running  (ch_run[i]),
            .count    (ch_count[i]),
            .init_val (ch_init[i])
        );
    end

    // Return the hit channel's word; zero when idle or unmapped.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_hit[i]) rdata = rd_word[i];
            end
        end
    end
endmodule

// File: rtl/ovt_checker.sv
// Checker: temporal properties of the timer, bound to the top module.
// Assumes the per-channel state vectors exported by the top.
module ovt_checker #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [1:0]                      wdata_lo,
    input logic [DATA_W-1:0]               rdata,
    input logic [NUM_CH-1:0]               irq,
    input logic [NUM_CH-1:0]               ch_flag,
    input logic [NUM_CH-1:0]               ch_en,
    input logic [NUM_CH-1:0]               ch_run,
    input logic [NUM_CH-1:0][CNT_W-1:0]    ch_count,
    input logic [NUM_CH-1:0][CNT_W-1:0]    ch_init
);
    import ovt_pkg::*;

    localparam int CHW = ADDR_W - CH_OFS_W;

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (irq == '0) && (ch_count == '0)); // R1

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr >= ADDR_W'(NUM_CH * CH_STRIDE))) |-> (rdata == '0)); // R12

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(i * CH_STRIDE) + ADDR_W'(OFS_STAT);
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(i * CH_STRIDE) + ADDR_W'(OFS_CTRL);

        AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (addr == A_CTRL) && (wdata_lo == 2'b10)) |=> (ch_count[i] == $past(ch_init[i]))); // R3

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_flag[i] && !(wr_en && (addr == A_STAT) && wdata_lo[0])) |=> ch_flag[i]); // R6

        AST_STOP_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (addr == A_CTRL) && wdata_lo[0]) |=> ((ch_count[i] == '0) && !ch_run[i])); // R9

        AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && !(wr_en && (addr[ADDR_W-1:CH_OFS_W] == CHW'(i)))) |=> $stable(ch_count[i])); // R10
    end
endmodule

bind ovt_timer_top ovt_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata_lo (wdata[1:0]),
    .rdata    (rdata),
    .irq      (irq),
    .ch_flag  (ch_flag),
    .ch_en    (ch_en),
    .ch_run   (ch_run),
    .ch_count (ch_count),
    .ch_init  (ch_init)
);

// File: tb/tb_ovt_timer_top.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_ovt_timer_top;
    localparam logic [9:0] C0 = 10'h000;
    localparam logic [9:0] C1 = 10'h040;
    localparam logic [9:0] STAT = 10'h00, VAL = 10'h04, CTRL = 10'h10;
    localparam logic [9:0] CFG = 10'h20, DIV = 10'h24, INIT = 10'h28;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;

    ovt_timer_top dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata), .irq (irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        chk("R1 irq", {30'b0, irq}, 32'h0);
        rd_chk("R1 c0 cfg", C0 + CFG, 0);
        rd_chk("R1 c0 val", C0 + VAL, 0);
        rd_chk("R1 c0 init", C0 + INIT, 0);
        @(negedge clk);
        rd_chk("R1 c1 div", C1 + DIV, 0);
        rd_chk("R1 c1 ctrl", C1 + CTRL, 0);
        rd_chk("R1 c1 stat", C1 + STAT, 0);
    endtask

    task automatic t_regmap;
        wr(C0 + DIV, 5);
        wr(C0 + INIT, 32'h0000_1234);
        wr(C0 + CFG, 2);
        wr(C1 + INIT, 32'h0000_BEEF);
        rd_chk("R2 c0 div", C0 + DIV, 5);
        rd_chk("R2 c0 init", C0 + INIT, 32'h1234);
        rd_chk("R2 c0 cfg", C0 + CFG, 2);
        @(negedge clk);
        rd_chk("R2 c1 init", C1 + INIT, 32'hBEEF);
        wr(C0 + DIV, 0);
        wr(C0 + CFG, 0);
    endtask

    task automatic t_count;
        wr(C0 + CFG, 1);
        wr(C0 + INIT, 100);
        wr(C0 + CTRL, 2);
        rd_chk("R3 load", C0 + VAL, 100);
        rd_chk("R3 ctrl run", C0 + CTRL, 2);
        @(negedge clk);
        rd_chk("R3 +1", C0 + VAL, 101);
        repeat (3) @(negedge clk);
        rd_chk("R3 +4", C0 + VAL, 104);
        wr(C0 + CTRL, 1);
    endtask

    task automatic t_overflow(input int n);
        bit early = 0;
        wr(C0 + CFG, 3);
        wr(C0 + INIT, ONES - n);
        wr(C0 + CTRL, 2);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (irq[0]) early = 1;
        end
        chk("R4 no early irq", {31'b0, early}, 0);
        @(negedge clk);
        chk("R4 irq on edge N+1", {31'b0, irq[0]}, 1);
        rd_chk("R4 reload", C0 + VAL, ONES - n);
        rd_chk("R6 stat set", C0 + STAT, 1);
        wr(C0 + CTRL, 1);
        wr(C0 + STAT, 0);
        rd_chk("R6 write 0 ignored", C0 + STAT, 1);
        wr(C0 + STAT, 1);
        rd_chk("R6 cleared", C0 + STAT, 0);
        chk("R6 irq low", {31'b0, irq[0]}, 0);
    endtask

    task automatic t_divider;
        wr(C0 + DIV, 2);
        wr(C0 + CFG, 1);
        wr(C0 + INIT, 10);
        wr(C0 + CTRL, 2);
        rd_chk("R5 start", C0 + VAL, 10);
        repeat (2) @(negedge clk);
        rd_chk("R5 hold 2 clk", C0 + VAL, 10);
        @(negedge clk);
        rd_chk("R5 first adv", C0 + VAL, 11);
        repeat (3) @(negedge clk);
        rd_chk("R5 second adv", C0 + VAL, 12);
        wr(C0 + CTRL, 1);
        wr(C0 + DIV, 0);
    endtask

    task automatic t_clear_race;
        wr(C0 + CFG, 1);
        wr(C0 + INIT, ONES - 3);
        wr(C0 + CTRL, 2);
        repeat (6) @(negedge clk);
        wr(C0 + STAT, 1);
        rd_chk("R7 overflow wins", C0 + STAT, 1);
        wr(C0 + STAT, 1);
        rd_chk("R7 plain clear", C0 + STAT, 0);
        wr(C0 + CTRL, 1);
        wr(C0 + STAT, 1);
    endtask

    task automatic t_irq_gate;
        wr(C0 + CFG, 1);
        wr(C0 + INIT, ONES - 2);
        wr(C0 + CTRL, 2);
        repeat (5) @(negedge clk);
        rd_chk("R8 flag set", C0 + STAT, 1);
        chk("R8 ie off", {31'b0, irq[0]}, 0);
        wr(C0 + CTRL, 1);
        rd_chk("R9 stop keeps flag", C0 + STAT, 1);
        wr(C0 + CFG, 3);
        chk("R8 both on", {31'b0, irq[0]}, 1);
        wr(C0 + CFG, 2);
        chk("R8 en off", {31'b0, irq[0]}, 0);
        wr(C0 + STAT, 1);
        wr(C0 + CFG, 3);
        chk("R8 flag off", {31'b0, irq[0]}, 0);
        wr(C0 + CFG, 0);
    endtask

    task automatic t_stop;
        wr(C0 + CFG, 1);
        wr(C0 + INIT, 500);
        wr(C0 + CTRL, 2);
        repeat (4) @(negedge clk);
        wr(C0 + CTRL, 3);
        rd_chk("R9 zeroed", C0 + VAL, 0);
        rd_chk("R9 ctrl idle", C0 + CTRL, 0);
        repeat (2) @(negedge clk);
        rd_chk("R9 stays stopped", C0 + VAL, 0);
    endtask

    task automatic t_freeze;
        wr(C0 + INIT, 700);
        wr(C0 + CTRL, 2);
        repeat (2) @(negedge clk);
        wr(C0 + CFG, 0);
        rd_chk("R10 frozen value", C0 + VAL, 704);
        repeat (3) @(negedge clk);
        rd_chk("R10 still frozen", C0 + VAL, 704);
        wr(C0 + CTRL, 1);
    endtask

    task automatic t_indep;
        wr(C1 + CFG, 3);
        wr(C1 + INIT, ONES - 2);
        wr(C1 + CTRL, 2);
        repeat (4) @(negedge clk);
        chk("R11 only ch1 irq", {30'b0, irq}, 32'h2);
        rd_chk("R11 ch0 count", C0 + VAL, 0);
        rd_chk("R11 ch0 flag", C0 + STAT, 0);
        wr(C1 + CTRL, 1);
        wr(C1 + STAT, 1);
        wr(C1 + CFG, 0);
    endtask

    task automatic t_unmapped;
        wr(C0 + INIT, 32'hA5A5);
        wr(C0 + DIV, 3);
        wr(10'h008, ONES);
        wr(10'h080, ONES);
        wr(10'h0A8, 32'h77);
        wr(10'h0A4, 32'h9);
        rd_chk("R12 hole", 10'h008, 0);
        rd_chk("R12 above", 10'h0A8, 0);
        rd_chk("R12 top", 10'h3FC, 0);
        @(negedge clk);
        rd_chk("R12 init kept", C0 + INIT, 32'hA5A5);
        rd_chk("R12 div kept", C0 + DIV, 3);
        rd_chk("R12 stat kept", C0 + STAT, 0);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_count();
        t_overflow(2);
        t_overflow(5);
        t_divider();
        t_clear_race();
        t_irq_gate();
        t_stop();
        t_freeze();
        t_indep();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule